// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer for a multicycle datapath that shares one memory and one ALU across the steps of an instruction. It walks each instruction through a common chain of states: fetch, decode with register read, execute, memory access and register write-back. In every state it drives the select, enable and function lines that steer the datapath. The sequence length depends on the instruction class. Branch and jump end after three states, register arithmetic and stores after four, and loads after five.

The only data input is the 6-bit opcode field held in the instruction register. The controller sees that field during the decode state and records the instruction class there. Later states use the recorded class, so a change in the instruction register after decode cannot redirect an instruction that is already running. All control outputs come straight from flip-flops and match the current state cycle for cycle. Reset is synchronous and active high.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer enters the fetch state, and the fetch control word appears on the outputs in the following cycle. This applies even when reset arrives partway through an instruction.
- R2: The fetch state lasts one cycle. In it, `mem_rd_en`, `ir_load` and `pc_load` are 1. `addr_from_alu` = 0 (memory address comes from the PC) and `alu_a_reg` = 0 (ALU A input is the PC). `alu_b_sel` = 01 (constant 4), `alu_fn` = 00 (add) and `pc_src` = 00 (next PC is the live ALU result). Every other output is 0.
- R3: Fetch is always followed by decode. Decode drives `alu_a_reg` = 0, `alu_b_sel` = 11 (sign-extended immediate shifted left 2) and `alu_fn` = 00, which places the branch target in ALUout. Every other output is 0.
- R4: Opcode 000000 (register arithmetic, add or sub) takes 4 cycles. Its execute state drives `alu_a_reg` = 1 and `alu_b_sel` = 00 (register B), with `alu_fn` = 10 (operation taken from the function field). Its write-back state drives `rf_wr_en` = 1, `dst_is_rd` = 1 and `wdata_from_mem` = 0. All other outputs are 0 in these states.
- R5: Opcode 100011 (load) takes 5 cycles. The address state drives `alu_a_reg` = 1, `alu_b_sel` = 10 (sign-extended immediate) and `alu_fn` = 00. The memory state drives `mem_rd_en` = 1 and `addr_from_alu` = 1. The write-back state drives `rf_wr_en` = 1, `wdata_from_mem` = 1 and `dst_is_rd` = 0. All other outputs are 0 in these states.
- R6: Opcode 101011 (store) takes 4 cycles. It uses the same address state as R5, followed by a memory state with `mem_wr_en` = 1 and `addr_from_alu` = 1, and all other outputs 0. It then returns to fetch.
- R7: Opcode 000100 (branch on equal) takes 3 cycles. Its execute state drives `pc_load_if_eq` = 1, `alu_a_reg` = 1, `alu_b_sel` = 00, `alu_fn` = 01 (subtract) and `pc_src` = 01 (ALUout), with all other outputs 0.
- R8: Opcode 000010 (jump) takes 3 cycles. Its execute state drives `pc_load` = 1 and `pc_src` = 10 (jump address), with all other outputs 0.
- R9: Any other opcode returns to fetch directly after decode, so the instruction takes 2 cycles and writes nothing.
- R10: The opcode is sampled only in the decode state. A change on `opcode` in any later state of the same instruction does not alter that instruction's sequence of control words.
- R11: `mem_rd_en` and `mem_wr_en` are never 1 together. No instruction runs more than 5 cycles before the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| addr_from_alu | output | 1 | Memory address source: 0 = PC, 1 = ALUout |
| mem_rd_en | output | 1 | Memory read |
| mem_wr_en | output | 1 | Memory write |
| ir_load | output | 1 | Load the instruction register |
| dst_is_rd | output | 1 | Write register: 1 = R-type destination field, 0 = rt |
| rf_wr_en | output | 1 | Register file write |
| wdata_from_mem | output | 1 | Register write data: 1 = memory data, 0 = ALUout |
| alu_a_reg | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 00 reg B, 01 four, 10 imm, 11 imm<<2 |
| alu_fn | output | 2 | ALU operation: 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | Next PC: 00 ALU result, 01 ALUout, 10 jump address |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_eq | output | 1 | PC write when the ALU result is zero |

## Verification
The fetch state does three things in one cycle. It reads memory at the PC, loads the instruction register, and writes PC+4 back to the PC through the same ALU. The jump execute state also writes the PC, but with a different source and without loading the instruction register. Every sequence in the stimulus table starts with a fetch, and the bench compares the whole control word of each cycle. Any mix-up between the PC update and the instruction load, in either state, therefore shows as a mismatched word. The bench also changes the opcode during the address state of a load and during the execute state of an R-type instruction, to confirm that the recorded class and not the live opcode steers the states that follow decode.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_MRD, S_MWR,
    S_LDWB, S_REXE, S_RWB, S_BEQ, S_JMP
  } state_e;

  typedef enum logic [2:0] {
    C_RTYPE, C_LOAD, C_STORE, C_BRANCH, C_JUMP, C_OTHER
  } class_e;

  localparam int N_CLASS = 5;

  localparam logic [SEL_W-1:0] B_REG  = 2'd0;
  localparam logic [SEL_W-1:0] B_FOUR = 2'd1;
  localparam logic [SEL_W-1:0] B_IMM  = 2'd2;
  localparam logic [SEL_W-1:0] B_IMM4 = 2'd3;

  localparam logic [SEL_W-1:0] FN_ADD   = 2'd0;
  localparam logic [SEL_W-1:0] FN_SUB   = 2'd1;
  localparam logic [SEL_W-1:0] FN_FUNCT = 2'd2;

  localparam logic [SEL_W-1:0] PC_ALU    = 2'd0;
  localparam logic [SEL_W-1:0] PC_ALUOUT = 2'd1;
  localparam logic [SEL_W-1:0] PC_JUMP   = 2'd2;

  typedef struct packed {
    logic             addr_alu;
    logic             mrd;
    logic             mwr;
    logic             irld;
    logic             dst_rd;
    logic             rfwr;
    logic             wd_mem;
    logic             a_reg;
    logic [SEL_W-1:0] b_sel;
    logic [SEL_W-1:0] fn;
    logic [SEL_W-1:0] pcsrc;
    logic             pcld;
    logic             pcld_eq;
  } ctl_t;

endpackage

// File: rtl/mcyc_opclass.sv
module mcyc_opclass
  import mcyc_pkg::*;
#(
  parameter int               OPW    = 6,
  parameter logic [OPW-1:0]   OP_R   = 6'b000000,
  parameter logic [OPW-1:0]   OP_LD  = 6'b100011,
  parameter logic [OPW-1:0]   OP_ST  = 6'b101011,
  parameter logic [OPW-1:0]   OP_BEQ = 6'b000100,
  parameter logic [OPW-1:0]   OP_J   = 6'b000010
) (
  input  logic [OPW-1:0] opcode,
  output class_e         cls
);

  localparam logic [OPW-1:0] CODES [N_CLASS] = '{OP_R, OP_LD, OP_ST, OP_BEQ, OP_J};
  localparam class_e         KINDS [N_CLASS] = '{C_RTYPE, C_LOAD, C_STORE, C_BRANCH, C_JUMP};

  logic [N_CLASS-1:0] hit;

  generate
    for (genvar i = 0; i < N_CLASS; i++) begin : g_match
      assign hit[i] = (opcode == CODES[i]);
    end
  endgenerate

  always_comb begin
    cls = C_OTHER;
    for (int i = N_CLASS - 1; i >= 0; i--) begin
      if (hit[i]) cls = KINDS[i];
    end
  end

endmodule

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
(
  input  state_e st,
  input  class_e live_cls,
  input  class_e held_cls,
  output state_e nxt
);

  always_comb begin
    nxt = S_FETCH;
    unique case (st)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (live_cls)
          C_RTYPE:          nxt = S_REXE;
          C_LOAD, C_STORE:  nxt = S_ADDR;
          C_BRANCH:         nxt = S_BEQ;
          C_JUMP:           nxt = S_JMP;
          default:          nxt = S_FETCH;
        endcase
      end
      S_ADDR:   nxt = (held_cls == C_LOAD) ? S_MRD : S_MWR;
      S_MRD:    nxt = S_LDWB;
      S_REXE:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
(
  input  state_e st,
  output ctl_t   c
);

  always_comb begin
    c = '0;
    unique case (st)
      S_FETCH: begin
        c.mrd   = 1'b1;
        c.irld  = 1'b1;
        c.pcld  = 1'b1;
        c.b_sel = B_FOUR;
        c.fn    = FN_ADD;
        c.pcsrc = PC_ALU;
      end
      S_DECODE: begin
        c.b_sel = B_IMM4;
        c.fn    = FN_ADD;
      end
      S_ADDR: begin
        c.a_reg = 1'b1;
        c.b_sel = B_IMM;
        c.fn    = FN_ADD;
      end
      S_MRD: begin
        c.mrd      = 1'b1;
        c.addr_alu = 1'b1;
      end
      S_MWR: begin
        c.mwr      = 1'b1;
        c.addr_alu = 1'b1;
      end
      S_LDWB: begin
        c.rfwr   = 1'b1;
        c.wd_mem = 1'b1;
      end
      S_REXE: begin
        c.a_reg = 1'b1;
        c.b_sel = B_REG;
        c.fn    = FN_FUNCT;
      end
      S_RWB: begin
        c.rfwr   = 1'b1;
        c.dst_rd = 1'b1;
      end
      S_BEQ: begin
        c.a_reg   = 1'b1;
        c.b_sel   = B_REG;
        c.fn      = FN_SUB;
        c.pcsrc   = PC_ALUOUT;
        c.pcld_eq = 1'b1;
      end
      S_JMP: begin
        c.pcld  = 1'b1;
        c.pcsrc = PC_JUMP;
      end
      default: c = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int             OPW    = 6,
  parameter logic [OPW-1:0] OP_R   = 6'b000000,
  parameter logic [OPW-1:0] OP_LD  = 6'b100011,
  parameter logic [OPW-1:0] OP_ST  = 6'b101011,
  parameter logic [OPW-1:0] OP_BEQ = 6'b000100,
  parameter logic [OPW-1:0] OP_J   = 6'b000010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   opcode,
  output logic             addr_from_alu,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic             ir_load,
  output logic             dst_is_rd,
  output logic             rf_wr_en,
  output logic             wdata_from_mem,
  output logic             alu_a_reg,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic [SEL_W-1:0] alu_fn,
  output logic [SEL_W-1:0] pc_src,
  output logic             pc_load,
  output logic             pc_load_if_eq
);

  state_e state_q, state_nxt, state_d;
  class_e cls_live, cls_q;
  ctl_t   ctl_d, ctl_q;

  mcyc_opclass #(
    .OPW(OPW), .OP_R(OP_R), .OP_LD(OP_LD), .OP_ST(OP_ST),
    .OP_BEQ(OP_BEQ), .OP_J(OP_J)
  ) i_opclass (
    .opcode (opcode),
    .cls    (cls_live)
  );

  mcyc_next i_next (
    .st       (state_q),
    .live_cls (cls_live),
    .held_cls (cls_q),
    .nxt      (state_nxt)
  );

  assign state_d = rst ? S_FETCH : state_nxt;

  mcyc_decode i_decode (
    .st (state_d),
    .c  (ctl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      cls_q   <= C_OTHER;
    end else begin
      state_q <= state_nxt;
      if (state_q == S_DECODE) cls_q <= cls_live;
    end
    ctl_q <= ctl_d;
  end

  assign addr_from_alu  = ctl_q.addr_alu;
  assign mem_rd_en      = ctl_q.mrd;
  assign mem_wr_en      = ctl_q.mwr;
  assign ir_load        = ctl_q.irld;
  assign dst_is_rd      = ctl_q.dst_rd;
  assign rf_wr_en       = ctl_q.rfwr;
  assign wdata_from_mem = ctl_q.wd_mem;
  assign alu_a_reg      = ctl_q.a_reg;
  assign alu_b_sel      = ctl_q.b_sel;
  assign alu_fn         = ctl_q.fn;
  assign pc_src         = ctl_q.pcsrc;
  assign pc_load        = ctl_q.pcld;
  assign pc_load_if_eq  = ctl_q.pcld_eq;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       addr_from_alu,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic       ir_load,
  input logic       rf_wr_en,
  input logic       alu_a_reg,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_fn,
  input logic [1:0] pc_src,
  input logic       pc_load,
  input logic       pc_load_if_eq
);

  logic [2:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || ir_load) run_len <= 3'd1;
    else if (run_len != 3'd7) run_len <= run_len + 3'd1;
  end

  a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  a_r11_max_len: assert property (@(posedge clk) disable iff (rst)
    (run_len >= 3'd5) |-> ir_load);

  a_r2_fetch_word: assert property (@(posedge clk) disable iff (rst)
    ir_load |-> (mem_rd_en && pc_load && !addr_from_alu && !alu_a_reg &&
                 alu_b_sel == 2'b01 && alu_fn == 2'b00 && pc_src == 2'b00));

  a_r3_decode_follows: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (!ir_load && !pc_load && alu_b_sel == 2'b11 && !alu_a_reg));

  a_r7_branch_word: assert property (@(posedge clk) disable iff (rst)
    pc_load_if_eq |-> (alu_fn == 2'b01 && pc_src == 2'b01 && alu_a_reg &&
                       alu_b_sel == 2'b00 && !pc_load));

  a_r6_store_ends: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> ir_load);

  a_r4_regwrite_ends: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> ir_load);

  a_r8_jump_ends: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !ir_load) |=> ir_load);

endmodule

bind mcyc_ctrl mcyc_ctrl_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .addr_from_alu (addr_from_alu),
  .mem_rd_en     (mem_rd_en),
  .mem_wr_en     (mem_wr_en),
  .ir_load       (ir_load),
  .rf_wr_en      (rf_wr_en),
  .alu_a_reg     (alu_a_reg),
  .alu_b_sel     (alu_b_sel),
  .alu_fn        (alu_fn),
  .pc_src        (pc_src),
  .pc_load       (pc_load),
  .pc_load_if_eq (pc_load_if_eq)
);

// File: tb/test_mcyc_ctrl.sv
`timescale 1ns/1ps
module test_mcyc_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic       addr_from_alu, mem_rd_en, mem_wr_en, ir_load, dst_is_rd;
  logic       rf_wr_en, wdata_from_mem, alu_a_reg, pc_load, pc_load_if_eq;
  logic [1:0] alu_b_sel, alu_fn, pc_src;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mcyc_ctrl i_mcyc_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode),
    .addr_from_alu(addr_from_alu), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .ir_load(ir_load), .dst_is_rd(dst_is_rd), .rf_wr_en(rf_wr_en),
    .wdata_from_mem(wdata_from_mem), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
    .alu_fn(alu_fn), .pc_src(pc_src), .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq)
  );

  function automatic logic [15:0] cw(input logic ia, input logic rd, input logic wr,
                                     input logic ir, input logic dr, input logic rw,
                                     input logic wm, input logic sa, input logic [1:0] sb,
                                     input logic [1:0] fn, input logic [1:0] ps,
                                     input logic pw, input logic pe);
    return {ia, rd, wr, ir, dr, rw, wm, sa, sb, fn, ps, pw, pe};
  endfunction

  localparam logic [15:0] W_F  = cw(0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00,1,0);
  localparam logic [15:0] W_D  = cw(0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00,0,0);
  localparam logic [15:0] W_A  = cw(0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0,0);
  localparam logic [15:0] W_MR = cw(1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00,0,0);
  localparam logic [15:0] W_MW = cw(1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00,0,0);
  localparam logic [15:0] W_LW = cw(0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00,0,0);
  localparam logic [15:0] W_RX = cw(0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00,0,0);
  localparam logic [15:0] W_RW = cw(0,0,0,0,1,1,0,0,2'b00,2'b00,2'b00,0,0);
  localparam logic [15:0] W_BQ = cw(0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01,0,1);
  localparam logic [15:0] W_JP = cw(0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10,1,0);

  localparam int NV = 6;
  localparam logic [88:0] VEC [NV] = '{
    {6'b000000, 3'd4, W_F, W_D, W_RX, W_RW, 16'h0},
    {6'b100011, 3'd5, W_F, W_D, W_A,  W_MR, W_LW },
    {6'b101011, 3'd4, W_F, W_D, W_A,  W_MW, 16'h0},
    {6'b000100, 3'd3, W_F, W_D, W_BQ, 16'h0, 16'h0},
    {6'b000010, 3'd3, W_F, W_D, W_JP, 16'h0, 16'h0},
    {6'b111111, 3'd2, W_F, W_D, 16'h0, 16'h0, 16'h0}
  };
  localparam string TAGS [NV] = '{"R4", "R5", "R6", "R7", "R8", "R9"};

  function automatic logic [15:0] got_word();
    return {addr_from_alu, mem_rd_en, mem_wr_en, ir_load, dst_is_rd, rf_wr_en,
            wdata_from_mem, alu_a_reg, alu_b_sel, alu_fn, pc_src, pc_load, pc_load_if_eq};
  endfunction

  task automatic check(input string tag, input int k, input logic [15:0] exp);
    logic [15:0] g;
    g = got_word();
    tests++;
    if (g !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, k, g, exp);
    end
    tests++;
    if (mem_rd_en && mem_wr_en) begin
      fails++;
      $display("FAIL R11 cycle %0d: read and write both high, got %b%b expected not both 1",
               k, mem_rd_en, mem_wr_en);
    end
  endtask

  // Runs one table entry from its fetch cycle; optionally changes the opcode at cycle chg_k.
  task automatic run_seq(input int idx, input string tag, input int chg_k,
                         input logic [5:0] chg_op);
    int len;
    len = int'(VEC[idx][82:80]);
    opcode = VEC[idx][88:83];
    for (int k = 0; k < len; k++) begin
      check(tag, k, VEC[idx][79-16*k -: 16]);
      if (k == chg_k) opcode = chg_op;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", 0, W_F);               // R1: fetch word after reset

    // Table walk: every instruction class, fetch (R2) and decode (R3) included
    for (int i = 0; i < NV; i++) run_seq(i, TAGS[i], -1, 6'b0);

    // Back-to-back mixed order
    run_seq(3, "R7", -1, 6'b0);
    run_seq(1, "R5", -1, 6'b0);
    run_seq(4, "R8", -1, 6'b0);
    run_seq(2, "R6", -1, 6'b0);

    // R10: opcode changes after decode are ignored
    run_seq(1, "R10", 2, 6'b101011);   // load, switched to store in address state
    run_seq(0, "R10", 2, 6'b000010);   // register op, switched to jump in execute
    run_seq(2, "R10", 2, 6'b100011);   // store, switched to load in address state

    // R1: reset in the middle of a load
    opcode = 6'b100011;
    check("R2", 0, W_F);
    @(posedge clk); @(negedge clk);
    check("R3", 1, W_D);
    @(posedge clk); @(negedge clk);
    check("R5", 2, W_A);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", 0, W_F);
    @(posedge clk); @(negedge clk);
    check("R1", 1, W_D);
    @(posedge clk); @(negedge clk);
    check("R1", 2, W_A);
    opcode = 6'b000000;
    @(posedge clk); @(negedge clk);
    check("R1", 3, W_MR);
    @(posedge clk); @(negedge clk);
    check("R1", 4, W_LW);
    @(posedge clk); @(negedge clk);

    // Register op after the interrupted sequence
    run_seq(0, "R4", -1, 6'b0);
    check("R11", 0, W_F);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule